// File: doc/BRIEF.md
# Serial Control-Port Register Bank

This block is a serial control-port slave that gives an external host read and write access to a bank of 32 byte-wide configuration registers. The host drives a serial clock, an active-low select and a data line. Read data comes back either on a separate output pin or on the shared data line, turned around for the read. All four pad signals are oversampled in the chip's own clock domain, so the whole block runs from one clock with one synchronous reset. The pads are described as plain level, output value and output-enable signals, and the tri-state buffers sit outside the block.

Each transaction begins with an instruction byte. It carries a read/write flag, a two-bit length field and a five-bit start address. One to four data bytes follow. An internal address counter walks through the bank from byte to byte. Two bits of register 0x00 set how the port behaves. One picks MSB-first or LSB-first bit order, and the bit order also fixes the direction of the address counter. The other picks four-wire operation, with a separate output pin, or three-wire operation, with a shared bidirectional pin. The full bank is also presented as a flat vector so that the rest of the chip can use the configuration values.

Top module: `spi_rf_top`

## Requirements
- R1: After reset, every register reads 0x00, both output enables are low, and the port works MSB-first in four-wire mode.
- R2: In canonical (MSB-first) form the instruction byte is bit 7 = read flag (1 read, 0 write), bits 6:5 = length field, bits 4:0 = start address. Output enables rise only during the data bytes of a read.
- R3: A length field of N moves N+1 data bytes. Any bytes clocked after the last one have no effect on the registers.
- R4: With register 0x00 bit 6 = 0, instruction and data bits go most-significant first. The address drops by one after each byte and stops at 0x00. Writes past that point are dropped, and reads past it return 0x00.
- R5: With register 0x00 bit 6 = 1, instruction and data bits go least-significant first. The address rises by one after each byte and stops at 0x1F. Writes past that point are dropped, and reads past it return 0x00.
- R6: Input bits are taken at rising serial-clock edges, and read bits are launched after falling edges. A register changes only on the system clock cycle after a detected rising edge.
- R7: With register 0x00 bit 7 = 0, read data appears on `sdo_o` with `sdo_oe` high, and `sdio_oe` stays low.
- R8: With register 0x00 bit 7 = 1, read data appears on `sdio_o` with `sdio_oe` high, and `sdo_oe` stays low.
- R9: While chip select is high, both output enables are low.
- R10: A write to register 0x00 changes bit order and pin mode only from the next transaction onward.
- R11: If chip select rises partway through a byte, that byte is discarded. The next transaction then starts afresh with an instruction byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock from the host, idle low |
| csb_i | input | 1 | Active-low chip select |
| sdio_i | input | 1 | Level seen on the shared data pin |
| sdio_o | output | 1 | Value driven on the shared data pin in three-wire reads |
| sdio_oe | output | 1 | Output enable for the shared data pin |
| sdo_o | output | 1 | Value driven on the separate output pin |
| sdo_oe | output | 1 | Output enable for the separate output pin |
| cfg_regs_o | output | 256 | Register bank, register k at bits 8k+7:8k |

## Verification
The bench builds the block with its default parameters: two synchroniser stages, eight-bit bytes and 32 registers. It runs a serial bit period of sixteen system clocks, which leaves a margin of several cycles between the synchronised launch of a read bit and the host's sampling point. The five-bit address space puts both saturation points, 0x00 and 0x1F, within reach of a single four-byte burst. In a single transaction the bench can therefore rewrite register 0x00, run into the lower limit, and show that the pending bit-order change has not yet taken effect.

// File: rtl/spi_rf_pkg.sv
package spi_rf_pkg;

    // Instruction layout fixes these widths; BYTE_W must be a power of two.
    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 5;
    localparam int LEN_W    = 2;
    localparam int NUM_REGS = 1 << ADDR_W;
    localparam int CNT_W    = $clog2(BYTE_W);

    // Control bits held in register 0x00
    localparam int CFG_ORDER_BIT = 6;
    localparam int CFG_WIRE_BIT  = 7;

    localparam logic [ADDR_W-1:0] ADDR_TOP = ADDR_W'(NUM_REGS - 1);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_INSTR,
        ST_DATA,
        ST_DONE
    } phase_e;

    typedef struct packed {
        logic              rd;
        logic [LEN_W-1:0]  len;
        logic [ADDR_W-1:0] addr;
    } instr_t;

    typedef struct packed {
        logic lsb_first;
        logic three_wire;
    } port_cfg_t;

    // Insert one serial bit into the byte being assembled
    function automatic logic [BYTE_W-1:0] shift_in(
        input logic [BYTE_W-1:0] sr,
        input logic              b,
        input logic              lsb
    );
        return lsb ? {b, sr[BYTE_W-1:1]} : {sr[BYTE_W-2:0], b};
    endfunction

    // Select the bit that goes on the wire at serial position idx
    function automatic logic pick_bit(
        input logic [BYTE_W-1:0] v,
        input logic [CNT_W-1:0]  idx,
        input logic              lsb
    );
        logic [CNT_W-1:0] pos;
        pos = lsb ? idx : ~idx;
        return v[pos];
    endfunction

    // Next byte address; top bit flags that the bank edge was hit
    function automatic logic [ADDR_W:0] step_addr(
        input logic [ADDR_W-1:0] a,
        input logic              lsb
    );
        if (lsb)
            return (a == ADDR_TOP) ? {1'b1, a} : {1'b0, a + ADDR_W'(1)};
        else
            return (a == '0) ? {1'b1, a} : {1'b0, a - ADDR_W'(1)};
    endfunction

    function automatic instr_t decode(input logic [BYTE_W-1:0] b);
        return instr_t'(b);
    endfunction

endpackage

// File: rtl/spi_rf_frontend.sv
module spi_rf_frontend #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk_i,
    input  logic csb_i,
    input  logic sdio_i,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic csb_s,
    output logic din_s
);
    localparam int          PW     = 3;
    localparam logic [PW-1:0] IDLE_V = 3'b010; // {sclk, csb, sdio}

    logic [PW-1:0] pipe [STAGES];
    logic          sclk_prev;
    logic          sclk_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) pipe[s] <= IDLE_V;
            sclk_prev <= 1'b0;
        end else begin
            pipe[0] <= {sclk_i, csb_i, sdio_i};
            for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
            sclk_prev <= sclk_s;
        end
    end

    assign sclk_s    = pipe[STAGES-1][2];
    assign csb_s     = pipe[STAGES-1][1];
    assign din_s     = pipe[STAGES-1][0];
    assign sclk_rise = sclk_s & ~sclk_prev;
    assign sclk_fall = ~sclk_s & sclk_prev;

endmodule

// File: rtl/spi_rf_regbank.sv
module spi_rf_regbank
    import spi_rf_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [BYTE_W-1:0]          wr_data,
    output logic [BYTE_W-1:0]          rd_data,
    output port_cfg_t                  cfg_live,
    output logic [NUM_REGS*BYTE_W-1:0] flat
);
    logic [BYTE_W-1:0] mem [NUM_REGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGS; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[addr] <= wr_data;
        end
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
        assign flat[g*BYTE_W +: BYTE_W] = mem[g];
    end

    assign rd_data             = mem[addr];
    assign cfg_live.lsb_first  = mem[0][CFG_ORDER_BIT];
    assign cfg_live.three_wire = mem[0][CFG_WIRE_BIT];

endmodule

// File: rtl/spi_rf_ctrl.sv
module spi_rf_ctrl
    import spi_rf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              csb_s,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              din,
    input  port_cfg_t         cfg_live,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_data,
    output logic [ADDR_W-1:0] addr,
    output logic              dout,
    output logic              sdo_oe,
    output logic              sdio_oe,
    output logic              busy,
    output logic              rd_txn,
    output port_cfg_t         cfg_q
);
    phase_e            phase;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] shnext;
    logic [LEN_W-1:0]  left;
    logic              past_end;
    logic              byte_done;
    logic              rd_phase;
    logic [ADDR_W:0]   stepped;
    logic [BYTE_W-1:0] out_byte;
    instr_t            ins;

    assign shnext    = shift_in(shreg, din, cfg_q.lsb_first);
    assign byte_done = sclk_rise && !csb_s && (bit_cnt == CNT_W'(BYTE_W-1));
    assign ins       = decode(shnext);
    assign stepped   = step_addr(addr, cfg_q.lsb_first);
    assign out_byte  = past_end ? '0 : rd_data;

    assign wr_en   = byte_done && (phase == ST_DATA) && !rd_txn && !past_end;
    assign wr_data = shnext;

    assign rd_phase = !csb_s && (phase == ST_DATA) && rd_txn;
    assign sdo_oe   = rd_phase && !cfg_q.three_wire;
    assign sdio_oe  = rd_phase && cfg_q.three_wire;
    assign busy     = (phase != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= ST_IDLE;
            bit_cnt  <= '0;
            shreg    <= '0;
            left     <= '0;
            past_end <= 1'b0;
            addr     <= '0;
            rd_txn   <= 1'b0;
            cfg_q    <= '0;
            dout     <= 1'b0;
        end else if (csb_s) begin
            // deselect: drop any partial byte
            phase   <= ST_IDLE;
            bit_cnt <= '0;
        end else begin
            if (phase == ST_IDLE) begin
                phase   <= ST_INSTR;
                bit_cnt <= '0;
                rd_txn  <= 1'b0;
                cfg_q   <= cfg_live;
            end else if (sclk_rise) begin
                shreg   <= shnext;
                bit_cnt <= bit_cnt + CNT_W'(1);
                if (byte_done) begin
                    unique case (phase)
                        ST_INSTR: begin
                            rd_txn   <= ins.rd;
                            left     <= ins.len;
                            addr     <= ins.addr;
                            past_end <= 1'b0;
                            phase    <= ST_DATA;
                        end
                        ST_DATA: begin
                            if (!past_end) {past_end, addr} <= stepped;
                            if (left == '0) phase <= ST_DONE;
                            else            left  <= left - LEN_W'(1);
                        end
                        default: ;
                    endcase
                end
            end
            if (sclk_fall && phase == ST_DATA)
                dout <= pick_bit(out_byte, bit_cnt, cfg_q.lsb_first);
        end
    end

endmodule

// File: rtl/spi_rf_top.sv
module spi_rf_top
    import spi_rf_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       sclk_i,
    input  logic                       csb_i,
    input  logic                       sdio_i,
    output logic                       sdio_o,
    output logic                       sdio_oe,
    output logic                       sdo_o,
    output logic                       sdo_oe,
    output logic [NUM_REGS*BYTE_W-1:0] cfg_regs_o
);
    logic              sclk_rise;
    logic              sclk_fall;
    logic              csb_s;
    logic              din_s;
    logic              wr_en;
    logic [BYTE_W-1:0] wr_data;
    logic [BYTE_W-1:0] rd_data;
    logic [ADDR_W-1:0] addr;
    logic              dout;
    logic              busy;
    logic              rd_txn;
    port_cfg_t         cfg_live;
    port_cfg_t         cfg_q;

    spi_rf_frontend #(.STAGES(SYNC_STAGES)) u_front (
        .clk      (clk),
        .rst      (rst),
        .sclk_i   (sclk_i),
        .csb_i    (csb_i),
        .sdio_i   (sdio_i),
        .sclk_rise(sclk_rise),
        .sclk_fall(sclk_fall),
        .csb_s    (csb_s),
        .din_s    (din_s)
    );

    spi_rf_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .csb_s    (csb_s),
        .sclk_rise(sclk_rise),
        .sclk_fall(sclk_fall),
        .din      (din_s),
        .cfg_live (cfg_live),
        .rd_data  (rd_data),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .addr     (addr),
        .dout     (dout),
        .sdo_oe   (sdo_oe),
        .sdio_oe  (sdio_oe),
        .busy     (busy),
        .rd_txn   (rd_txn),
        .cfg_q    (cfg_q)
    );

    spi_rf_regbank u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .cfg_live(cfg_live),
        .flat    (cfg_regs_o)
    );

    assign sdo_o  = dout;
    assign sdio_o = dout;

endmodule

// File: rtl/spi_rf_chk.sv
module spi_rf_chk
    import spi_rf_pkg::*;
(
    input logic                       clk,
    input logic                       rst,
    input logic                       csb_s,
    input logic                       sclk_rise,
    input logic                       busy,
    input logic                       rd_txn,
    input port_cfg_t                  cfg_q,
    input logic                       sdo_oe,
    input logic                       sdio_oe,
    input logic [NUM_REGS*BYTE_W-1:0] regs
);

    AST_HIZ_DESELECTED: assert property (@(posedge clk) disable iff (rst)
        csb_s |-> (!sdo_oe && !sdio_oe)); // R9

    AST_DRIVE_ONLY_READ: assert property (@(posedge clk) disable iff (rst)
        (sdo_oe || sdio_oe) |-> rd_txn); // R2

    AST_SDO_FOUR_WIRE: assert property (@(posedge clk) disable iff (rst)
        sdo_oe |-> !cfg_q.three_wire); // R7

    AST_SDIO_THREE_WIRE: assert property (@(posedge clk) disable iff (rst)
        sdio_oe |-> cfg_q.three_wire); // R8

    AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(cfg_q)); // R10

    AST_REGS_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        !$past(sclk_rise) |-> $stable(regs)); // R6

    AST_NO_WRITE_DESELECTED: assert property (@(posedge clk) disable iff (rst)
        $past(csb_s) |-> $stable(regs)); // R11

endmodule

bind spi_rf_top spi_rf_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .csb_s    (csb_s),
    .sclk_rise(sclk_rise),
    .busy     (busy),
    .rd_txn   (rd_txn),
    .cfg_q    (cfg_q),
    .sdo_oe   (sdo_oe),
    .sdio_oe  (sdio_oe),
    .regs     (cfg_regs_o)
);

// File: tb/tb_spi_rf_top.sv
`timescale 1ns/1ps
module tb_spi_rf_top;

    localparam int HALF = 8;   // system clocks per serial half period

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sclk_i = 1'b0;
    logic         csb_i = 1'b1;
    logic         sdio_i = 1'b0;
    logic         sdio_o, sdio_oe, sdo_o, sdo_oe;
    logic [255:0] cfg_regs_o;

    int errors = 0;
    int checks = 0;
    bit done   = 0;
    logic [7:0] model [32];

    always #2 clk = ~clk;   // 250 MHz

    spi_rf_top dut (
        .clk(clk), .rst(rst), .sclk_i(sclk_i), .csb_i(csb_i), .sdio_i(sdio_i),
        .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdo_o(sdo_o), .sdo_oe(sdo_oe),
        .cfg_regs_o(cfg_regs_o)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ins(input bit rd, input int len, input int a);
        return {rd, 2'(len), 5'(a)};
    endfunction

    task automatic chk_reg(input string req, input int a);
        chk(req, 64'(cfg_regs_o[a*8 +: 8]), 64'(model[a]));
    endtask

    // One framed transaction; frm byte 0 is the instruction in canonical form
    task automatic xfer(input logic [47:0] frm, input int nbits, input bit lsb,
                        input bit three_w, output logic [47:0] cap,
                        output bit sdo_seen, output bit sdio_seen, output bit ins_oe);
        cap = '0; sdo_seen = 0; sdio_seen = 0; ins_oe = 0;
        csb_i = 1'b0;
        tick(6);
        for (int i = 0; i < nbits; i++) begin
            int b   = i / 8;
            int j   = i % 8;
            int pos = lsb ? j : 7 - j;
            sdio_i = frm[b*8 + pos];
            tick(HALF);
            if (b == 0) ins_oe = ins_oe | sdo_oe | sdio_oe;
            else begin
                sdo_seen  = sdo_seen | sdo_oe;
                sdio_seen = sdio_seen | sdio_oe;
                cap[b*8 + pos] = three_w ? sdio_o : sdo_o;
            end
            sclk_i = 1'b1;
            tick(HALF);
            sclk_i = 1'b0;
        end
        tick(HALF);
        csb_i = 1'b1;
        sdio_i = 1'b0;
        tick(8);
    endtask

    task automatic t_reset;
        for (int a = 0; a < 32; a++) model[a] = 8'h00;
        chk("R1 bank cleared", 64'(cfg_regs_o), 64'h0);
        chk("R1 upper bank cleared", 64'(cfg_regs_o[255:192]), 64'h0);
        chk("R1 oe low", {62'h0, sdo_oe, sdio_oe}, 64'h0);
    endtask

    task automatic t_msb_burst;
        logic [47:0] cap; bit so, si, io;
        xfer({8'hCC, 8'hBB, 8'hAA, ins(0, 2, 5)}, 32, 0, 0, cap, so, si, io);
        model[5] = 8'hAA; model[4] = 8'hBB; model[3] = 8'hCC;
        chk_reg("R4 msb burst addr5", 5);
        chk_reg("R4 msb burst addr4", 4);
        chk_reg("R2 msb burst addr3", 3);
        chk("R9 oe low after write", {62'h0, sdo_oe, sdio_oe}, 64'h0);
        xfer({24'h0, ins(1, 2, 5)}, 32, 0, 0, cap, so, si, io);
        chk("R6 msb readback", 64'(cap[31:8]), 64'hCCBBAA);
        chk("R7 sdo drives", 64'(so), 64'h1);
        chk("R7 sdio quiet", 64'(si), 64'h0);
        chk("R2 no oe in instruction", 64'(io), 64'h0);
    endtask

    task automatic t_msb_sat;
        logic [47:0] cap; bit so, si, io;
        xfer({8'h44, 8'h33, 8'h22, 8'h11, ins(0, 3, 1)}, 40, 0, 0, cap, so, si, io);
        model[1] = 8'h11; model[0] = 8'h22;
        chk_reg("R4 sat addr1", 1);
        chk_reg("R4 sat addr0 keeps first", 0);
        chk("R4 no wrap to 0x1F", 64'(cfg_regs_o[31*8 +: 8]), 64'h0);
        xfer({32'h0, ins(1, 3, 1)}, 40, 0, 0, cap, so, si, io);
        chk("R4 read past floor", 64'(cap[39:8]), 64'h00002211);
        xfer({8'h00, ins(0, 0, 0)}, 16, 0, 0, cap, so, si, io);
        model[0] = 8'h00;
        chk_reg("R4 restore reg0", 0);
    endtask

    task automatic t_extra_bytes;
        logic [47:0] cap; bit so, si, io;
        model[8] = 8'h00;
        xfer({8'h5C, 8'h9D, ins(0, 0, 9)}, 24, 0, 0, cap, so, si, io);
        model[9] = 8'h9D;
        chk_reg("R3 single byte written", 9);
        chk_reg("R3 extra byte ignored", 8);
    endtask

    task automatic t_cfg_deferred;
        logic [47:0] cap; bit so, si, io;
        // reg0 <- LSB-first; a live switch would step up and write reg1
        xfer({8'h1E, 8'h40, ins(0, 1, 0)}, 24, 0, 0, cap, so, si, io);
        model[0] = 8'h40;
        chk_reg("R10 reg0 written", 0);
        chk_reg("R10 order unchanged mid-transaction", 1);
    endtask

    task automatic t_lsb;
        logic [47:0] cap; bit so, si, io;
        xfer({8'h56, 8'h34, 8'h12, ins(0, 2, 30)}, 32, 1, 0, cap, so, si, io);
        model[30] = 8'h12; model[31] = 8'h34;
        chk_reg("R5 lsb addr30", 30);
        chk_reg("R5 lsb addr31", 31);
        chk_reg("R5 no wrap to reg0", 0);
        xfer({24'h0, ins(1, 2, 30)}, 32, 1, 0, cap, so, si, io);
        chk("R5 lsb read past ceiling", 64'(cap[31:8]), 64'h003412);
        xfer({8'h00, ins(0, 0, 0)}, 16, 1, 0, cap, so, si, io);
        model[0] = 8'h00;
        chk_reg("R5 restore reg0", 0);
    endtask

    task automatic t_three_wire;
        logic [47:0] cap; bit so, si, io;
        xfer({8'h80, ins(0, 0, 0)}, 16, 0, 0, cap, so, si, io);
        model[0] = 8'h80;
        xfer({8'h0, ins(1, 0, 5)}, 16, 0, 1, cap, so, si, io);
        chk("R8 read on shared pin", 64'(cap[15:8]), 64'(model[5]));
        chk("R8 sdio drives", 64'(si), 64'h1);
        chk("R8 sdo quiet", 64'(so), 64'h0);
        chk("R9 hi-z after read", {62'h0, sdo_oe, sdio_oe}, 64'h0);
        xfer({8'h00, ins(0, 0, 0)}, 16, 0, 1, cap, so, si, io);
        model[0] = 8'h00;
        chk_reg("R8 restore reg0", 0);
    endtask

    task automatic t_abort;
        logic [47:0] cap; bit so, si, io;
        model[7] = 8'h00;
        xfer({8'hF0, ins(0, 0, 7)}, 12, 0, 0, cap, so, si, io);
        chk_reg("R11 partial data byte dropped", 7);
        xfer({8'h00, ins(0, 0, 7)}, 5, 0, 0, cap, so, si, io);
        chk_reg("R11 partial instruction dropped", 7);
        xfer({8'h77, ins(0, 0, 7)}, 16, 0, 0, cap, so, si, io);
        model[7] = 8'h77;
        chk_reg("R11 next transaction clean", 7);
        xfer({8'h0, ins(1, 0, 7)}, 16, 0, 0, cap, so, si, io);
        chk("R11 readback after abort", 64'(cap[15:8]), 64'h77);
    endtask

    initial begin
        tick(5);
        rst = 1'b0;
        tick(3);
        t_reset();
        t_msb_burst();
        t_msb_sat();
        t_extra_bytes();
        t_cfg_deferred();
        t_lsb();
        t_three_wire();
        t_abort();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule